// File: doc/BRIEF.md
# Three-Port Program Register File

This block holds the eight 32-bit general-purpose registers of a small processor core. Each cycle it serves two independent reads and one write. Registers are named by a 4-bit identifier. Values 0 through 7 select a physical register. Value 8 is the reserved "no register" code, and the remaining values 9 through 15 behave the same way.

The read ports are purely combinational: a data output follows its identifier input within the same cycle, with no clock edge involved. The write port commits its data on the rising clock edge. The core's decode stage can park any port on the no-register code when an instruction has no operand or no destination. A synchronous active-low reset clears every register to zero.

Top module: `tri_port_regfile`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, all eight registers hold zero after that edge.
- R2: When `wr_id` is in the range 0 to 7 at a rising edge, `wr_data` is stored in that register and can be read back after the edge.
- R3: When `wr_id` is in the range 8 to 15 (8 being the no-register code), the edge changes no register.
- R4: `rd_a_data` equals the register selected by `rd_a_id` (0 to 7) within the same cycle, with no clock edge needed.
- R5: `rd_b_data` equals the register selected by `rd_b_id` (0 to 7), independently of port A.
- R6: A read port whose identifier is in the range 8 to 15 outputs zero.
- R7: While a register is being written, a read of that register returns its old value until the edge, and the new value from the edge on.
- R8: A write changes only the addressed register; the other seven keep their values.
- R9: Both read ports may select the same register, and two reads and one write all take effect in a single cycle.
- R10: When reset and a valid write occur at the same edge, reset wins and the addressed register ends at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_id | input | 4 | Register identifier for read port A |
| rd_a_data | output | 32 | Combinational read data for port A |
| rd_b_id | input | 4 | Register identifier for read port B |
| rd_b_data | output | 32 | Combinational read data for port B |
| wr_id | input | 4 | Register identifier for the write port (8 to 15 means no write) |
| wr_data | input | 32 | Data stored at the rising edge |

## Verification
The bench goes after four corner cases:

- **Ignored writes.** It sweeps identifiers 8 to 15 on the write port and then reads all eight registers. A design that truncated the identifier to three bits would fail here, because it would overwrite a register from a no-register write.
- **Out-of-range reads.** It reads identifiers 8 to 15 on both ports. A mux that ignored the high identifier bit would return the contents of a real register instead of zero.
- **Read during write.** It reads a register while it is being written and checks the value before and after the edge. A file that bypassed the write data onto the read path would return the new value too early.
- **Reset with a write.** It pairs reset with a write at the same edge. A design that gave the write priority would leave data behind after reset.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int DEF_DATA_W   = 32;
    localparam int DEF_ID_W     = 4;
    localparam int DEF_NUM_REGS = 8;

    // Architectural register names; GPR_NONE is the no-access code
    typedef enum logic [DEF_ID_W-1:0] {
        GPR0     = 4'd0,
        GPR1     = 4'd1,
        GPR2     = 4'd2,
        GPR3     = 4'd3,
        GPR4     = 4'd4,
        GPR5     = 4'd5,
        GPR6     = 4'd6,
        GPR7     = 4'd7,
        GPR_NONE = 4'd8
    } gpr_id_e;

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int ID_W     = regfile_pkg::DEF_ID_W,
    parameter int NUM_REGS = regfile_pkg::DEF_NUM_REGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     wr_id,
    output logic [NUM_REGS-1:0] wr_en
);

    localparam logic [ID_W-1:0] FIRST_BAD_ID = ID_W'(NUM_REGS);

    always_comb begin
        wr_en = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_id == ID_W'(i)) begin
                wr_en[i] = 1'b1;
            end
        end
    end

    // R3
    ignore_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_id >= FIRST_BAD_ID) |-> (wr_en == '0));

    // R8
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_id < FIRST_BAD_ID) |-> ($countones(wr_en) == 1));

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W   = regfile_pkg::DEF_DATA_W,
    parameter int NUM_REGS = regfile_pkg::DEF_NUM_REGS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_REGS-1:0]               wr_en,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   bank
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t st_d;
    bank_t st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.regs = '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_en[i]) begin
                    st_d.regs[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bank = st_q.regs;

    // R1 and R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (bank == '0));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg_chk
        // R2
        wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> (bank[g] == $past(wr_data)));
        // R8
        untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(bank[g]));
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DATA_W   = regfile_pkg::DEF_DATA_W,
    parameter int ID_W     = regfile_pkg::DEF_ID_W,
    parameter int NUM_REGS = regfile_pkg::DEF_NUM_REGS
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] bank,
    input  logic [ID_W-1:0]                 rd_id,
    output logic [DATA_W-1:0]               rd_data
);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_id == ID_W'(i)) begin
                rd_data = bank[i];
            end
        end
    end

endmodule

// File: rtl/tri_port_regfile.sv
module tri_port_regfile #(
    parameter int DATA_W   = regfile_pkg::DEF_DATA_W,
    parameter int ID_W     = regfile_pkg::DEF_ID_W,
    parameter int NUM_REGS = regfile_pkg::DEF_NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int              NUM_RD       = 2;
    localparam logic [ID_W-1:0] FIRST_BAD_ID = ID_W'(NUM_REGS);

    logic [NUM_REGS-1:0]             wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] bank;
    logic [NUM_RD-1:0][ID_W-1:0]     rd_ids;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_vals;

    rf_wr_decode #(
        .ID_W     (ID_W),
        .NUM_REGS (NUM_REGS)
    ) u_wr_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_id (wr_id),
        .wr_en (wr_en)
    );

    rf_storage #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_storage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bank    (bank)
    );

    assign rd_ids[0] = rd_a_id;
    assign rd_ids[1] = rd_b_id;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(
            .DATA_W   (DATA_W),
            .ID_W     (ID_W),
            .NUM_REGS (NUM_REGS)
        ) u_rd (
            .bank    (bank),
            .rd_id   (rd_ids[p]),
            .rd_data (rd_vals[p])
        );
    end

    assign rd_a_data = rd_vals[0];
    assign rd_b_data = rd_vals[1];

    // R6
    rd_a_none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_id >= FIRST_BAD_ID) |-> (rd_a_data == '0));

    // R6
    rd_b_none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_id >= FIRST_BAD_ID) |-> (rd_b_data == '0));

    // R7
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_id < FIRST_BAD_ID) |=>
            ((rd_a_id != $past(wr_id)) || (rd_a_data == $past(wr_data))));

    // R9
    same_reg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data));

endmodule

// File: tb/tri_port_regfile_bench.sv
module tri_port_regfile_bench;

    localparam int DW = 32;
    localparam int IW = 4;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [IW-1:0] rd_a_id, rd_b_id, wr_id;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data;

    logic [DW-1:0] model [NR];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    tri_port_regfile #(.DATA_W(DW), .ID_W(IW), .NUM_REGS(NR)) u_tri_port_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_id   (rd_a_id),
        .rd_a_data (rd_a_data),
        .rd_b_id   (rd_b_id),
        .rd_b_data (rd_b_data),
        .wr_id     (wr_id),
        .wr_data   (wr_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [IW-1:0] id, input logic [DW-1:0] d);
        @(negedge clk);
        wr_id   = id;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_id = 4'd8;
        if (id < NR) model[id] = d;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NR; i++) begin
            rd_a_id = IW'(i);
            rd_b_id = IW'(NR - 1 - i);
            #1;
            check({req, " portA"}, rd_a_data, model[i]);
            check({req, " portB"}, rd_b_data, model[NR - 1 - i]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) model[i] = '0;
        read_all("R1 reset clears");
    endtask

    task automatic t_write_all();
        for (int i = 0; i < NR; i++) do_write(IW'(i), 32'hA5000000 + DW'(i * 32'h01010101));
        read_all("R2 R4 R5 write then read");
        do_write(4'd3, 32'hDEADBEEF);
        read_all("R8 only target changes");
        do_write(4'd0, 32'hFFFFFFFF);
        do_write(4'd7, 32'h00000001);
        read_all("R2 edge registers");
    endtask

    task automatic t_ignored_ids();
        for (int id = 8; id < 16; id++) do_write(IW'(id), 32'hBAD00000 + DW'(id));
        read_all("R3 no-register writes ignored");
        for (int id = 8; id < 16; id++) begin
            @(negedge clk);
            rd_a_id = IW'(id);
            rd_b_id = IW'(id);
            #1;
            check("R6 none-read portA zero", rd_a_data, '0);
            check("R6 none-read portB zero", rd_b_data, '0);
        end
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        rd_a_id = 4'd5;
        rd_b_id = 4'd2;
        wr_id   = 4'd5;
        wr_data = 32'h12345678;
        #1;
        check("R7 old value before edge", rd_a_data, model[5]);
        check("R9 concurrent read portB", rd_b_data, model[2]);
        @(posedge clk);
        #1;
        wr_id = 4'd8;
        model[5] = 32'h12345678;
        check("R7 new value after edge", rd_a_data, model[5]);
        check("R9 portB unaffected", rd_b_data, model[2]);
    endtask

    task automatic t_dual_read();
        for (int i = 0; i < NR; i++) begin
            @(negedge clk);
            rd_a_id = IW'(i);
            rd_b_id = IW'(i);
            #1;
            check("R9 same reg portA", rd_a_data, model[i]);
            check("R9 same reg portB", rd_b_data, model[i]);
        end
        @(negedge clk);
        rd_a_id = 4'd1;
        #1;
        check("R4 comb read no edge", rd_a_data, model[1]);
        rd_a_id = 4'd6;
        #1;
        check("R4 comb read follows id", rd_a_data, model[6]);
    endtask

    task automatic t_reset_priority();
        @(negedge clk);
        rst_n   = 1'b0;
        wr_id   = 4'd4;
        wr_data = 32'hCAFEF00D;
        @(posedge clk);
        #1;
        wr_id = 4'd8;
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) model[i] = '0;
        read_all("R10 reset beats write");
    endtask

    initial begin
        rst_n   = 1'b0;
        rd_a_id = 4'd8;
        rd_b_id = 4'd8;
        wr_id   = 4'd8;
        wr_data = '0;
        for (int i = 0; i < NR; i++) model[i] = '0;
        t_reset();
        t_write_all();
        t_ignored_ids();
        t_same_cycle();
        t_dual_read();
        t_reset_priority();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule